// File: doc/BRIEF.md
# Paged Host Register File for a Clock Chip

This block is the register file a host processor sees when it talks to a calendar clock chip. The host drives a 5-bit location number, an 8-bit write value and active-low select, read and write strobes. All of these are brought into the block clock domain through a short synchroniser chain. The block then turns them into reads and writes across two 32-location pages. Location 0 of either page is one shared status byte. Its low bit picks the page and its next bit picks which of two control-register banks appears on page 0.

On page 0, the locations just above the status byte are a small banked control area held inside the block. The rest of page 0 goes out on a narrow port to the neighbouring blocks, which hold the clock counters, alarm compare bytes and time-save bytes. Page 1 above the status byte is plain scratch storage. A power-fail input, active low, locks out the host. While it is asserted, no new access can start and the read drivers stay off. A write whose strobe was already low when the lockout began still completes.

Top module: `paged_regfile`

## Requirements
- R1: After reset the status byte, every control byte and every scratch byte read as 0x00, and the read output enable is low.
- R2: The read output enable is high only while select and read are both low (seen after the input synchroniser) and lockout is not active. A read strobe without select never enables the bus.
- R3: A write takes effect once, when select or write returns high. It uses the location and value present on the last synchronised cycle in which both were low. Select low alone, with write high, changes nothing.
- R4: Location 0 is the same status byte on both pages. Status bit 0 selects page 1 when set and page 0 when clear, and it can be written from either page.
- R5: On page 1, locations 1 to 31 are scratch bytes kept apart from the page 0 contents at the same locations.
- R6: On page 0, locations 1 to 3 are control bytes in two banks. Status bit 1 selects bank 1 when set and bank 0 when clear, and each bank keeps its own values.
- R7: On page 0, locations 4 to 31 belong to the neighbouring blocks. A write there gives a one-cycle write pulse with the location and value on the external port, and a read returns the external read data.
- R8: While the power-fail input is low, new write strobes are ignored. A strobe that went low during lockout does not commit, even if lockout ends before the strobe does.
- R9: A write whose strobe was low before lockout began still commits when its strobe ends.
- R10: While lockout is active, the read output enable stays low.
- R11: Status bits 7 to 2 act as general storage and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Host select, active low |
| rdN | input | 1 | Host read strobe, active low |
| wrN | input | 1 | Host write strobe, active low |
| pfailN | input | 1 | Power-fail lockout request, active low |
| addr | input | 5 | Host location number |
| dataIn | input | 8 | Host write value |
| dataOut | output | 8 | Host read value, zero while not enabled |
| dataOe | output | 1 | Read output enable for the bus driver |
| extWrEn | output | 1 | One-cycle write pulse toward the neighbouring blocks |
| extAddr | output | 5 | Location number toward the neighbouring blocks |
| extWrData | output | 8 | Write value toward the neighbouring blocks |
| extRdData | input | 8 | Read value from the neighbouring blocks |

## Verification
On every cycle, the assertions check that the output enable and the external write pulse follow only from strobe states seen two clocks earlier, and that lockout keeps the enable off. They also check that external pulses are single cycles landing inside the page 0 external window. The directed scenarios are the only evidence for the page and bank separation, the shared status byte, and which value a write commits when it changes mid-strobe. They also show that a write already in flight finishes under lockout, while a strobe that began during lockout never commits.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    TGT_STATUS,
    TGT_CTRL,
    TGT_SCRATCH,
    TGT_EXT
  } tgt_e;

  typedef struct packed {
    logic              commit;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } busStrobe_t;
endpackage

// File: rtl/pgreg_ctrl.sv
module pgreg_ctrl
  import pgreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              pfailN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output busStrobe_t        strb
);
  localparam int CW = 4;
  localparam int PW = ADDR_W + DATA_W;
  localparam int VW = CW + PW;

  logic [VW-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= {{CW{1'b1}}, {PW{1'b0}}};
    end else begin
      stg[0] <= {pfailN, wrN, rdN, csN, addr, dataIn};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  logic [VW-1:0]     syncd;
  logic [DATA_W-1:0] dataS;
  logic [ADDR_W-1:0] addrS;
  logic              csS, rdS, wrS, pfS;

  assign syncd = stg[SYNC_STAGES-1];
  assign dataS = syncd[DATA_W-1:0];
  assign addrS = syncd[DATA_W +: ADDR_W];
  assign csS   = syncd[PW];
  assign rdS   = syncd[PW+1];
  assign wrS   = syncd[PW+2];
  assign pfS   = syncd[PW+3];

  logic lockS, writeLow, readLow;
  assign lockS    = ~pfS;
  assign writeLow = ~csS & ~wrS;
  assign readLow  = ~csS & ~rdS;

  logic              prevWriteLow, wrActive;
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWriteLow <= 1'b0;
      wrActive     <= 1'b0;
      addrHold     <= '0;
      dataHold     <= '0;
    end else begin
      prevWriteLow <= writeLow;
      if (!wrActive) begin
        if (writeLow && !prevWriteLow && !lockS) begin
          wrActive <= 1'b1;
          addrHold <= addrS;
          dataHold <= dataS;
        end
      end else if (writeLow) begin
        if (!lockS) begin
          addrHold <= addrS;
          dataHold <= dataS;
        end
      end else begin
        wrActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.commit = wrActive & ~writeLow;
    strb.wrAddr = addrHold;
    strb.wrData = dataHold;
    strb.rdEn   = readLow & ~lockS;
    strb.rdAddr = addrS;
  end
endmodule

// File: rtl/pgreg_dp.sv
module pgreg_dp
  import pgreg_pkg::*;
#(
  parameter int CTRL_REGS = 3,
  parameter int PAGE_BIT  = 0,
  parameter int BANK_BIT  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              extWrEn,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWrData,
  input  logic [DATA_W-1:0] extRdData
);
  localparam int LOCS    = 1 << ADDR_W;
  localparam int SCR_N   = LOCS - 1;
  localparam int CTRL_N  = 2 * CTRL_REGS;

  logic [DATA_W-1:0] statusQ;
  logic              pageSel, bankSel;
  assign pageSel = statusQ[PAGE_BIT];
  assign bankSel = statusQ[BANK_BIT];

  function automatic tgt_e decodeTgt(logic [ADDR_W-1:0] a, logic page);
    if (a == '0)                        return TGT_STATUS;
    else if (page)                      return TGT_SCRATCH;
    else if (a <= ADDR_W'(CTRL_REGS))   return TGT_CTRL;
    else                                return TGT_EXT;
  endfunction

  tgt_e wrTgt, rdTgt;
  assign wrTgt = decodeTgt(strb.wrAddr, pageSel);
  assign rdTgt = decodeTgt(strb.rdAddr, pageSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else if (strb.commit && wrTgt == TGT_STATUS) statusQ <= strb.wrData;
  end

  logic [CTRL_N-1:0][DATA_W-1:0] ctrlFlat;
  logic [SCR_N-1:0][DATA_W-1:0]  scrFlat;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar r = 0; r < CTRL_REGS; r++) begin : g_ctrl
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= '0;
          else if (strb.commit && wrTgt == TGT_CTRL && bankSel == 1'(b) &&
                   strb.wrAddr == ADDR_W'(r + 1)) q <= strb.wrData;
        end
        assign ctrlFlat[b*CTRL_REGS + r] = q;
      end
    end
    for (genvar s = 0; s < SCR_N; s++) begin : g_scr
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.commit && wrTgt == TGT_SCRATCH &&
                 strb.wrAddr == ADDR_W'(s + 1)) q <= strb.wrData;
      end
      assign scrFlat[s] = q;
    end
  endgenerate

  logic [DATA_W-1:0] rdVal;
  always_comb begin
    rdVal = '0;
    unique case (rdTgt)
      TGT_STATUS: rdVal = statusQ;
      TGT_EXT:    rdVal = extRdData;
      TGT_CTRL: begin
        for (int b = 0; b < 2; b++)
          for (int r = 0; r < CTRL_REGS; r++)
            if (bankSel == 1'(b) && strb.rdAddr == ADDR_W'(r + 1))
              rdVal = ctrlFlat[b*CTRL_REGS + r];
      end
      TGT_SCRATCH: begin
        for (int s = 0; s < SCR_N; s++)
          if (strb.rdAddr == ADDR_W'(s + 1)) rdVal = scrFlat[s];
      end
      default: rdVal = '0;
    endcase
  end

  assign dataOe    = strb.rdEn;
  assign dataOut   = strb.rdEn ? rdVal : '0;
  assign extWrEn   = strb.commit && wrTgt == TGT_EXT;
  assign extAddr   = strb.commit ? strb.wrAddr : strb.rdAddr;
  assign extWrData = strb.wrData;
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile
  import pgreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_REGS   = 3,
  parameter int PAGE_BIT    = 0,
  parameter int BANK_BIT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              pfailN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              extWrEn,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWrData,
  input  logic [DATA_W-1:0] extRdData
);
  busStrobe_t strb;

  pgreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .pfailN(pfailN), .addr(addr), .dataIn(dataIn), .strb(strb)
  );

  pgreg_dp #(.CTRL_REGS(CTRL_REGS), .PAGE_BIT(PAGE_BIT), .BANK_BIT(BANK_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dataOut(dataOut), .dataOe(dataOe),
    .extWrEn(extWrEn), .extAddr(extAddr), .extWrData(extWrData),
    .extRdData(extRdData)
  );
endmodule

// File: rtl/pgreg_chk.sv
module pgreg_chk
  import pgreg_pkg::*;
#(
  parameter int CTRL_REGS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic              pfailN,
  input logic              dataOe,
  input logic              extWrEn,
  input logic [ADDR_W-1:0] extAddr
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R2: enable only after select and read were both low
  a_r2_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rstN || upCnt != 2'd3)
    dataOe |-> (!$past(csN, 2) && !$past(rdN, 2)));

  // R10: lockout holds the enable off
  a_r10_oe_off_locked: assert property (@(posedge clk) disable iff (!rstN || upCnt != 2'd3)
    !$past(pfailN, 2) |-> !dataOe);

  // R3: a commit follows a released strobe
  a_r3_commit_on_release: assert property (@(posedge clk) disable iff (!rstN || upCnt != 2'd3)
    extWrEn |-> ($past(csN, 2) || $past(wrN, 2)));

  // R7: external pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    extWrEn |=> !extWrEn);

  // R7: external pulse stays in the external window
  a_r7_ext_window: assert property (@(posedge clk) disable iff (!rstN)
    extWrEn |-> (extAddr > ADDR_W'(CTRL_REGS)));
endmodule

bind paged_regfile pgreg_chk #(.CTRL_REGS(CTRL_REGS)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .pfailN(pfailN),
  .dataOe(dataOe), .extWrEn(extWrEn), .extAddr(extAddr)
);

// File: tb/paged_regfile_tb_top.sv
module paged_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1, pfailN = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, extWrData, extRdData;
  logic       dataOe, extWrEn;
  logic [4:0] extAddr;

  int checks = 0, errors = 0, extPulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_regfile dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .pfailN(pfailN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .extWrEn(extWrEn), .extAddr(extAddr), .extWrData(extWrData),
    .extRdData(extRdData)
  );

  logic [7:0] extMem [32];
  assign extRdData = extMem[extAddr];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) extMem[i] <= '0;
    end else if (extWrEn) begin
      extMem[extAddr] <= extWrData;
      extPulses <= extPulses + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; csN = 0; wrN = 0;
    waitN(5);
    wrN = 1; csN = 1;
    waitN(6);
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; csN = 0; rdN = 0;
    waitN(4);
    d = dataOut; oe = dataOe;
    rdN = 1; csN = 1;
    waitN(4);
  endtask

  task automatic readChk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d; logic oe;
    hostRead(a, d, oe);
    chk({req, " oe"}, int'(oe), 1);
    chk(req, int'(d), int'(exp));
  endtask

  task automatic t_reset();
    chk("R1 oe idle", int'(dataOe), 0);
    readChk("R1 status", 5'd0, 8'h00);
    readChk("R1 ctrl", 5'd2, 8'h00);
    hostWrite(5'd0, 8'h01);
    readChk("R1 scratch", 5'd17, 8'h00);
    hostWrite(5'd0, 8'h00);
  endtask

  task automatic t_status();
    hostWrite(5'd0, 8'hA4);
    readChk("R11 status store", 5'd0, 8'hA4);
    hostWrite(5'd0, 8'h00);
  endtask

  task automatic t_pages();
    int p0;
    hostWrite(5'd2, 8'h11);
    hostWrite(5'd0, 8'h01);
    readChk("R4 status on page1", 5'd0, 8'h01);
    hostWrite(5'd2, 8'h22);
    p0 = extPulses;
    hostWrite(5'd31, 8'h5A);
    chk("R5 page1 high loc not external", extPulses, p0);
    readChk("R5 page1 scratch", 5'd2, 8'h22);
    readChk("R5 page1 top", 5'd31, 8'h5A);
    hostWrite(5'd0, 8'h00);
    readChk("R4 page cleared from page1", 5'd0, 8'h00);
    readChk("R5 page0 kept", 5'd2, 8'h11);
  endtask

  task automatic t_bank();
    hostWrite(5'd1, 8'h33);
    hostWrite(5'd0, 8'h02);
    hostWrite(5'd1, 8'h44);
    readChk("R6 bank1", 5'd1, 8'h44);
    hostWrite(5'd0, 8'h00);
    readChk("R6 bank0", 5'd1, 8'h33);
  endtask

  task automatic t_ext();
    int p0 = extPulses;
    hostWrite(5'd9, 8'hC3);
    chk("R7 one pulse", extPulses, p0 + 1);
    chk("R7 ext data", int'(extMem[9]), 8'hC3);
    readChk("R7 ext read", 5'd9, 8'hC3);
  endtask

  task automatic t_strobe();
    logic [7:0] d; logic oe;
    @(negedge clk);
    addr = 5'd3; dataIn = 8'h10; csN = 0;
    waitN(6);
    csN = 1;
    waitN(6);
    readChk("R3 select alone no write", 5'd3, 8'h00);
    @(negedge clk);
    addr = 5'd3; dataIn = 8'h10; csN = 0; wrN = 0;
    waitN(4);
    dataIn = 8'h20;
    waitN(4);
    csN = 1;
    waitN(3);
    wrN = 1;
    waitN(6);
    readChk("R3 last value, select release", 5'd3, 8'h20);
    @(negedge clk);
    addr = 5'd3; rdN = 0;
    waitN(4);
    d = dataOut; oe = dataOe;
    rdN = 1;
    waitN(4);
    chk("R2 read without select", int'(oe), 0);
  endtask

  task automatic t_lock();
    logic [7:0] d; logic oe;
    pfailN = 0;
    waitN(4);
    hostRead(5'd3, d, oe);
    chk("R10 oe off in lockout", int'(oe), 0);
    hostWrite(5'd3, 8'h99);
    pfailN = 1;
    waitN(4);
    readChk("R8 write blocked", 5'd3, 8'h20);
    @(negedge clk);
    addr = 5'd3; dataIn = 8'h66; csN = 0; wrN = 0;
    waitN(5);
    pfailN = 0;
    waitN(4);
    wrN = 1; csN = 1;
    waitN(6);
    pfailN = 1;
    waitN(4);
    readChk("R9 in-flight write done", 5'd3, 8'h66);
    pfailN = 0;
    waitN(4);
    @(negedge clk);
    addr = 5'd3; dataIn = 8'h77; csN = 0; wrN = 0;
    waitN(4);
    pfailN = 1;
    waitN(5);
    wrN = 1; csN = 1;
    waitN(6);
    readChk("R8 strobe from lockout dropped", 5'd3, 8'h66);
  endtask

  initial begin
    waitN(3);
    rstN = 1;
    waitN(3);
    t_reset();
    t_status();
    t_pages();
    t_bank();
    t_ext();
    t_strobe();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule